// File: doc/BRIEF.md
# Serial Port Register File and Interrupt Controller

This block is the processor-facing side of a classic PC-style asynchronous serial controller. A host reaches eight byte-wide registers through a 3-bit offset together with separate read and write strobes. Reads are registered, so the data of a read strobed in one cycle appears on `rdata` in the next cycle. Bytes that arrive from an outside receiver are pushed into an internal receive queue. Bytes that the host writes for transmission leave on a one-cycle strobe. The block decides which interrupt source is reported and drives the interrupt request line.

One parameter, `CHIP_GEN` (0 to 4), selects the controller generation:

| Generation | Scratch register | Receive-queue control | Interrupt request |
|---|---|---|---|
| 0 | absent | ignored | pulsed |
| 1 | present | ignored | pulsed |
| 2 | present | ignored | level |
| 3 | present | ignored | level |
| 4 | present | accepted | level |

A small state machine drives the request line. It has four states: `IRQ_QUIET`, `IRQ_PULSE`, `IRQ_HOLD` and `IRQ_LEVEL`.

- **Level generations.** The machine moves `IRQ_QUIET -> IRQ_LEVEL` when a gated cause appears. It moves `IRQ_LEVEL -> IRQ_QUIET` when the cause goes away.
- **Pulsed generations.** The machine moves `IRQ_QUIET -> IRQ_PULSE`, then `IRQ_PULSE -> IRQ_HOLD` after one cycle. It moves `IRQ_HOLD -> IRQ_PULSE` when the reported source changes to another pending one. `IRQ_PULSE` and `IRQ_HOLD` both return to `IRQ_QUIET` once nothing gated is pending.

Top module: `uart_csr_core`

## Requirements
- R1: After reset the line status register reads 0x60, the interrupt identification reads 0x01, and every other register reads 0x00. `irq` and `tx_strobe` are low.
- R2: Bit 7 of the line control register (offset 3) selects divisor access. While it is set, offsets 0 and 1 read and write the divisor low and high bytes. Such accesses touch neither the transmitter, the receive queue nor the enable register.
- R3: Offset 1, with divisor access off, is the interrupt enable register. Bit 0 enables received data and timeout, bit 1 enables transmit-empty, bit 2 enables line status, and bit 3 is storable. Writes keep only bits 3:0, so bits 7:4 always read 0.
- R4: A write to offset 0, with divisor access off, drives `tx_strobe` high for exactly the next cycle with `tx_byte` equal to the written byte. It also marks a transmit-empty interrupt as pending. Line status bits 5 and 6 stay set.
- R5: Received bytes are read from offset 0 in arrival order, one per read, and each read removes one byte. Line status bit 0 is 1 exactly while the queue holds data. A read of an empty queue returns 0x00.
- R6: A push into a full queue discards the byte and sets line status bit 1. A read of the line status register (offset 5) returns that bit and then clears it, which also clears the line-status interrupt.
- R7: The identification value at offset 2 reports the highest-priority enabled pending cause in bits 3:0, in this order: line status 0x6, receive timeout 0xC, received data 0x4, transmit-empty 0x2. When nothing is pending it reads 0x1.
- R8: A read of offset 2 that reports transmit-empty clears the pending transmit interrupt. A read that reports any other cause leaves it pending.
- R9: When modem control bit 4 (loopback) is set, a transmit write also enters the receive queue, and `rx_push` is ignored. Modem control reads back bits 4:0.
- R10: Only generation 4 accepts writes to offset 2 (the queue control register). When bit 0 of that register is set, the identification value carries 11 in bits 7:6, and an `rx_stale` pulse with data waiting raises the timeout cause. That cause clears on a data read.
- R11: The scratch register at offset 7 stores any byte on generations 1 to 4. On generation 0 it reads 0x00.
- R12: `irq` is forced low unless modem control bit 3 is set. On generations 2 to 4 it is a level, high from the second cycle after a gated cause appears until the cause is gone. On generations 0 and 1 it is a single-cycle pulse for each newly reported cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data appears on `rdata` the next cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_push | input | 1 | Pushes `rx_byte` into the receive queue |
| rx_byte | input | 8 | Received byte |
| rx_stale | input | 1 | Pulse from an outside timer marking receive inactivity |
| tx_strobe | output | 1 | One-cycle strobe for a byte to transmit |
| tx_byte | output | 8 | Byte to transmit, valid with `tx_strobe` |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume that the host never raises `wr_en` and `rd_en` in the same cycle. They also assume that every strobe lasts one cycle per access, with `addr` stable during that cycle. The bench keeps to these rules by issuing every register access through a task that drives a single strobe for one cycle, always on the falling edge. Receive pushes and stale pulses come from separate tasks and never overlap a host access. As a result, every side effect of a read or write can be tied to a single known clock edge.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int BYTE_W = 8;

    // register offsets
    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_ENABLE = 3'd1;
    localparam logic [2:0] OFS_IDENT  = 3'd2;
    localparam logic [2:0] OFS_LINECT = 3'd3;
    localparam logic [2:0] OFS_MODEM  = 3'd4;
    localparam logic [2:0] OFS_LSTAT  = 3'd5;
    localparam logic [2:0] OFS_MSTAT  = 3'd6;
    localparam logic [2:0] OFS_SCRAT  = 3'd7;

    // identification codes (low nibble)
    localparam logic [3:0] ID_NONE   = 4'h1;
    localparam logic [3:0] ID_TXMT   = 4'h2;
    localparam logic [3:0] ID_RXDATA = 4'h4;
    localparam logic [3:0] ID_LINE   = 4'h6;
    localparam logic [3:0] ID_RXTMO  = 4'hC;

    // generation at which features appear
    localparam int GEN_SCRATCH = 1;
    localparam int GEN_LEVEL   = 2;
    localparam int GEN_QCTRL   = 4;

    typedef enum logic [1:0] {
        IRQ_QUIET = 2'd0,
        IRQ_PULSE = 2'd1,
        IRQ_HOLD  = 2'd2,
        IRQ_LEVEL = 2'd3
    } irq_state_e;

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] fill;
    logic          take, give;

    assign take  = push && !full;
    assign give  = pop && !empty;
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
    assign head  = store[rptr];

    always_ff @(posedge clk) begin
        if (take) begin
            store[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (take) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (give) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            unique case ({take, give})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
    import uart_csr_pkg::*;
#(
    parameter bit PULSE_MODE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate,
    input  logic       line_req,
    input  logic       tmo_req,
    input  logic       rx_req,
    input  logic       tx_req,
    output logic [3:0] ident,
    output logic       irq
);
    irq_state_e state_q, state_d;
    logic [3:0] seen_q;
    logic       live;

    // fixed priority encoder
    always_comb begin
        if (line_req) begin
            ident = ID_LINE;
        end else if (tmo_req) begin
            ident = ID_RXTMO;
        end else if (rx_req) begin
            ident = ID_RXDATA;
        end else if (tx_req) begin
            ident = ID_TXMT;
        end else begin
            ident = ID_NONE;
        end
    end

    assign live = gate && (ident != ID_NONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (live) begin
                    state_d = PULSE_MODE ? IRQ_PULSE : IRQ_LEVEL;
                end
            end
            IRQ_LEVEL: begin
                if (!live) begin
                    state_d = IRQ_QUIET;
                end
            end
            IRQ_PULSE: begin
                state_d = live ? IRQ_HOLD : IRQ_QUIET;
            end
            IRQ_HOLD: begin
                if (!live) begin
                    state_d = IRQ_QUIET;
                end else if (ident != seen_q) begin
                    state_d = IRQ_PULSE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
            seen_q  <= ID_NONE;
        end else begin
            state_q <= state_d;
            if (state_d == IRQ_PULSE) begin
                seen_q <= ident;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_PULSE, IRQ_LEVEL: irq = 1'b1;
            default:              irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_csr_core.sv
module uart_csr_core
    import uart_csr_pkg::*;
#(
    parameter int CHIP_GEN  = 4,
    parameter int RXQ_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_stale,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);
    localparam bit PULSE_MODE = (CHIP_GEN < GEN_LEVEL);
    localparam int IER_BITS   = 4;
    localparam int MCR_BITS   = 5;

    logic [BYTE_W-1:0]   div_lo_q, div_hi_q, lcr_q, scr_q;
    logic [IER_BITS-1:0] ier_q;
    logic [MCR_BITS-1:0] mcr_q;
    logic                oe_q, txp_q, tmo_q, qen_q;
    logic                tx_strobe_q;
    logic [BYTE_W-1:0]   tx_byte_q, rdata_q;

    logic dlab, loop, out2, qmode;
    logic wr_data, rd_data, rd_ident, rd_lstat;
    logic q_push, q_empty, q_full, overflow;
    logic [BYTE_W-1:0] q_in, q_head;
    logic [3:0]        ident;
    logic [BYTE_W-1:0] ident_byte, lstat_byte, rd_mux;

    assign dlab  = lcr_q[7];
    assign loop  = mcr_q[4];
    assign out2  = mcr_q[3];
    assign qmode = qen_q;

    assign wr_data  = wr_en && (addr == OFS_DATA) && !dlab;
    assign rd_data  = rd_en && (addr == OFS_DATA) && !dlab;
    assign rd_ident = rd_en && (addr == OFS_IDENT);
    assign rd_lstat = rd_en && (addr == OFS_LSTAT);

    // receive path: loopback replaces the outside source
    assign q_push   = loop ? wr_data : rx_push;
    assign q_in     = loop ? wdata : rx_byte;
    assign overflow = q_push && q_full;

    uart_rxq #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_in),
        .pop       (rd_data),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    uart_irq_ctl #(.PULSE_MODE(PULSE_MODE)) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (out2),
        .line_req (oe_q && ier_q[2]),
        .tmo_req  (tmo_q && ier_q[0]),
        .rx_req   (!q_empty && ier_q[0]),
        .tx_req   (txp_q && ier_q[1]),
        .ident    (ident),
        .irq      (irq)
    );

    // core register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo_q <= '0;
            div_hi_q <= '0;
            lcr_q    <= '0;
            ier_q    <= '0;
            mcr_q    <= '0;
            oe_q     <= 1'b0;
            txp_q    <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    OFS_DATA:   if (dlab) div_lo_q <= wdata;
                    OFS_ENABLE: begin
                        if (dlab) div_hi_q <= wdata;
                        else      ier_q    <= wdata[IER_BITS-1:0];
                    end
                    OFS_LINECT: lcr_q <= wdata;
                    OFS_MODEM:  mcr_q <= wdata[MCR_BITS-1:0];
                    default: ;
                endcase
            end
            if (wr_data) begin
                txp_q <= 1'b1;
            end else if (rd_ident && (ident == ID_TXMT)) begin
                txp_q <= 1'b0;
            end
            if (overflow) begin
                oe_q <= 1'b1;
            end else if (rd_lstat) begin
                oe_q <= 1'b0;
            end
            if (rd_data || q_empty) begin
                tmo_q <= 1'b0;
            end else if (rx_stale && qmode) begin
                tmo_q <= 1'b1;
            end
        end
    end

    // generation-dependent registers
    generate
        if (CHIP_GEN >= GEN_SCRATCH) begin : g_scratch
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scr_q <= '0;
                end else if (wr_en && (addr == OFS_SCRAT)) begin
                    scr_q <= wdata;
                end
            end
        end else begin : g_no_scratch
            assign scr_q = '0;
        end

        if (CHIP_GEN >= GEN_QCTRL) begin : g_qctrl
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    qen_q <= 1'b0;
                end else if (wr_en && (addr == OFS_IDENT)) begin
                    qen_q <= wdata[0];
                end
            end
        end else begin : g_no_qctrl
            assign qen_q = 1'b0;
        end
    endgenerate

    // read data
    assign ident_byte = {(qmode ? 2'b11 : 2'b00), 2'b00, ident};
    assign lstat_byte = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, !q_empty};

    always_comb begin
        unique case (addr)
            OFS_DATA:   rd_mux = dlab ? div_lo_q : (q_empty ? '0 : q_head);
            OFS_ENABLE: rd_mux = dlab ? div_hi_q : {{(BYTE_W-IER_BITS){1'b0}}, ier_q};
            OFS_IDENT:  rd_mux = ident_byte;
            OFS_LINECT: rd_mux = lcr_q;
            OFS_MODEM:  rd_mux = {{(BYTE_W-MCR_BITS){1'b0}}, mcr_q};
            OFS_LSTAT:  rd_mux = lstat_byte;
            OFS_MSTAT:  rd_mux = '0;
            OFS_SCRAT:  rd_mux = scr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q     <= '0;
            tx_strobe_q <= 1'b0;
            tx_byte_q   <= '0;
        end else begin
            if (rd_en) begin
                rdata_q <= rd_mux;
            end
            tx_strobe_q <= wr_data;
            if (wr_data) begin
                tx_byte_q <= wdata;
            end
        end
    end

    assign rdata     = rdata_q;
    assign tx_strobe = tx_strobe_q;
    assign tx_byte   = tx_byte_q;

endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk #(
    parameter int CHIP_GEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       tx_strobe,
    input logic       irq,
    input logic       out2,
    input logic       dlab,
    input logic       q_push,
    input logic       q_full,
    input logic       oe
);

    // R12: request only follows an enabled gate
    a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(out2));

    // R4: strobe only follows a transmit write
    a_r4_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(wr_en && (addr == 3'd0) && !dlab));

    // R6: a push into a full queue marks overrun
    a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && q_full) |=> oe);

    // R3: upper enable bits read zero
    a_r3_enable_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 3'd1) && !dlab) |=> (rdata[7:4] == 4'h0));

    generate
        if (CHIP_GEN < 2) begin : g_pulse
            // R12: pulsed request lasts one cycle
            a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                irq |=> !irq);
        end
        if (CHIP_GEN == 0) begin : g_noscr
            // R11: scratch absent on generation 0
            a_r11_scratch_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && (addr == 3'd7)) |=> (rdata == 8'h00));
        end
    endgenerate

endmodule

bind uart_csr_core uart_csr_chk #(.CHIP_GEN(CHIP_GEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .tx_strobe (tx_strobe),
    .irq       (irq),
    .out2      (mcr_q[3]),
    .dlab      (lcr_q[7]),
    .q_push    (q_push),
    .q_full    (q_full),
    .oe        (oe_q)
);

// File: tb/uart_csr_core_tb_top.sv
module uart_csr_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, rx_push = 1'b0, rx_stale = 1'b0;
    logic [7:0] wdata = '0, rx_byte = '0;
    logic [7:0] rdata_i, rdata_o, txb_i, txb_o;
    logic       txs_i, txs_o, irq_i, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_csr_core #(.CHIP_GEN(4), .RXQ_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata_i), .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_stale(rx_stale), .tx_strobe(txs_i), .tx_byte(txb_i), .irq(irq_i));

    uart_csr_core #(.CHIP_GEN(0), .RXQ_DEPTH(DEPTH)) dut_o (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata_o), .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_stale(rx_stale), .tx_strobe(txs_o), .tx_byte(txb_o), .irq(irq_o));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] vi, output logic [7:0] vo);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        vi = rdata_i; vo = rdata_o;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        rx_byte = d; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic stale();
        @(negedge clk);
        rx_stale = 1'b1;
        @(negedge clk);
        rx_stale = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin : stim
        logic [7:0] vi, vo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_i", {7'd0, irq_i}, 8'h00);
        check("R1 irq_o", {7'd0, irq_o}, 8'h00);
        check("R1 tx_strobe", {7'd0, txs_i}, 8'h00);
        rd(3'd5, vi, vo); check("R1 lsr_i", vi, 8'h60); check("R1 lsr_o", vo, 8'h60);
        rd(3'd2, vi, vo); check("R1 iir_i", vi, 8'h01); check("R1 iir_o", vo, 8'h01);
        for (int a = 0; a < 8; a++) begin
            if (a != 2 && a != 5) begin
                rd(a[2:0], vi, vo);
                check("R1 reg_i", vi, 8'h00);
                check("R1 reg_o", vo, 8'h00);
            end
        end

        // R11 scratch sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd7, v[7:0]);
            rd(3'd7, vi, vo);
            check("R11 scratch_i", vi, v[7:0]);
            check("R11 scratch_o", vo, 8'h00);
        end

        // R2 divisor sweep
        wr(3'd3, 8'h80);
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, v[7:0]);
            check("R2 no_tx", {7'd0, txs_i}, 8'h00);
            wr(3'd1, ~v[7:0]);
            rd(3'd0, vi, vo);
            check("R2 div_lo", vi, v[7:0]); check("R2 div_lo_o", vo, v[7:0]);
            rd(3'd1, vi, vo);
            check("R2 div_hi", vi, ~v[7:0]); check("R2 div_hi_o", vo, ~v[7:0]);
        end
        wr(3'd3, 8'h03);
        rd(3'd3, vi, vo); check("R2 lcr", vi, 8'h03);
        rd(3'd1, vi, vo); check("R2 ier_untouched", vi, 8'h00);
        rd(3'd5, vi, vo); check("R2 lsr_untouched", vi, 8'h60);

        // R3 enable sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd1, v[7:0]);
            rd(3'd1, vi, vo);
            check("R3 ier", vi, v[7:0] & 8'h0F);
        end
        wr(3'd1, 8'h00);

        // R5 receive order
        push(8'hA1); push(8'hB2); push(8'hC3);
        rd(3'd5, vi, vo); check("R5 dr_set", vi, 8'h61);
        rd(3'd0, vi, vo); check("R5 rx0", vi, 8'hA1);
        rd(3'd0, vi, vo); check("R5 rx1", vi, 8'hB2);
        rd(3'd0, vi, vo); check("R5 rx2", vi, 8'hC3); check("R5 rx2_o", vo, 8'hC3);
        rd(3'd5, vi, vo); check("R5 dr_clear", vi, 8'h60);
        rd(3'd0, vi, vo); check("R5 empty_read", vi, 8'h00);

        // R6 overrun
        for (int k = 0; k < DEPTH + 1; k++) push(8'h10 + 8'(k));
        rd(3'd5, vi, vo); check("R6 oe_set", vi, 8'h63);
        rd(3'd5, vi, vo); check("R6 oe_clear", vi, 8'h61);
        for (int k = 0; k < DEPTH; k++) begin
            rd(3'd0, vi, vo); check("R6 kept", vi, 8'h10 + 8'(k));
        end
        rd(3'd5, vi, vo); check("R6 drained", vi, 8'h60);

        // R4, R7, R8, R12 interrupt flow
        wr(3'd4, 8'h08);
        wr(3'd1, 8'h07);
        wr(3'd0, 8'h55);
        check("R4 strobe", {7'd0, txs_i}, 8'h01);
        check("R4 byte", txb_i, 8'h55);
        check("R12 pulse_late", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        check("R4 strobe_one", {7'd0, txs_i}, 8'h00);
        check("R12 level_on", {7'd0, irq_i}, 8'h01);
        check("R12 pulse_on", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        check("R12 level_hold", {7'd0, irq_i}, 8'h01);
        check("R12 pulse_off", {7'd0, irq_o}, 8'h00);
        rd(3'd2, vi, vo); check("R8 iir_tx", vi, 8'h02); check("R8 iir_tx_o", vo, 8'h02);
        rd(3'd2, vi, vo); check("R8 tx_cleared", vi, 8'h01);
        @(negedge clk);
        check("R12 level_off", {7'd0, irq_i}, 8'h00);
        push(8'h11);
        wr(3'd0, 8'h22);
        rd(3'd2, vi, vo); check("R7 rx_over_tx", vi, 8'h04);
        for (int k = 0; k < DEPTH; k++) push(8'h20 + 8'(k));
        rd(3'd2, vi, vo); check("R7 line_top", vi, 8'h06); check("R7 line_top_o", vo, 8'h06);
        rd(3'd5, vi, vo); check("R6 lsr_oe", vi, 8'h63);
        rd(3'd2, vi, vo); check("R7 line_gone", vi, 8'h04);
        rd(3'd0, vi, vo); check("R5 seq0", vi, 8'h11);
        for (int k = 0; k < DEPTH - 1; k++) begin
            rd(3'd0, vi, vo); check("R5 seq", vi, 8'h20 + 8'(k));
        end
        rd(3'd2, vi, vo); check("R8 tx_kept", vi, 8'h02);
        rd(3'd2, vi, vo); check("R8 tx_done", vi, 8'h01);

        // R9 loopback
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h18);
        rd(3'd4, vi, vo); check("R9 mcr", vi, 8'h18);
        push(8'hAA);
        rd(3'd5, vi, vo); check("R9 ext_ignored", vi, 8'h60);
        wr(3'd0, 8'h3C);
        rd(3'd5, vi, vo); check("R9 echo_dr", vi, 8'h61);
        rd(3'd0, vi, vo); check("R9 echo", vi, 8'h3C); check("R9 echo_o", vo, 8'h3C);
        wr(3'd4, 8'h08);

        // R10 queue control and timeout
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h01);
        rd(3'd2, vi, vo); check("R10 fifo_bits", vi, 8'hC1); check("R10 ignored_o", vo, 8'h01);
        push(8'h77);
        rd(3'd2, vi, vo); check("R10 rx_id", vi, 8'hC4); check("R10 rx_id_o", vo, 8'h04);
        stale();
        rd(3'd2, vi, vo); check("R10 timeout", vi, 8'hCC); check("R10 no_tmo_o", vo, 8'h04);
        rd(3'd0, vi, vo); check("R10 data", vi, 8'h77);
        rd(3'd2, vi, vo); check("R10 tmo_clear", vi, 8'hC1); check("R10 clear_o", vo, 8'h01);

        // R12 gate
        push(8'h5A);
        wr(3'd4, 8'h00);
        @(negedge clk);
        check("R12 gated_i", {7'd0, irq_i}, 8'h00);
        check("R12 gated_o", {7'd0, irq_o}, 8'h00);
        wr(3'd4, 8'h08);
        @(negedge clk);
        check("R12 ungated_i", {7'd0, irq_i}, 8'h01);
        check("R12 ungated_o", {7'd0, irq_o}, 8'h01);
        rd(3'd0, vi, vo); check("R5 last", vi, 8'h5A);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule